// File: doc/BRIEF.md
# Two-Wire Slave Register Front End

This block is a receive-side front end for a two-wire serial bus (I2C). It sits between the bus pins and a small register file. A fast system clock oversamples the clock and data lines, which first pass through synchronizers. The block recognises bus start and stop conditions and shifts in an address byte. It answers only to a seven-bit address built from a fixed six-bit prefix and one strap input. A second strap value therefore gives a second slave on the same bus.

In a write, the first byte after the address loads an internal register pointer. Each further byte becomes a one-cycle write strobe carrying the pointer and the byte. The pointer then steps by one. In a read, the byte that the register file returns for the current pointer is shifted out on the data line. This continues for as long as the master acknowledges. The data line is open-drain: the block only ever asks the pad to pull low.

Top module: `twi_cmd_slave`

## Requirements
- R1: After reset, `sdaPullLow` is 0, `regWrEn` is 0 and `regAddr` is 0.
- R2: A fall of the data line while the clock line is high is a start condition. It restarts the address phase from any point, including the middle of a byte. A rise of the data line while the clock line is high is a stop condition; it releases the data line and makes the block idle.
- R3: The address byte is received MSB first, with the top seven bits as the address and bit 0 as the direction (0 = write, 1 = read). The address matches when the seven bits equal `ADDR_PREFIX` (default 011100) followed by `addrStrap`. On a match, `sdaPullLow` is 1 throughout the high phase of the ninth clock.
- R4: A non-matching address gets no acknowledge. After it, no write strobe and no pointer change occur and the data line is never pulled until the next start condition.
- R5: In a write, the first byte after the address is loaded into the pointer and appears on `regAddr`. A stop condition right after that byte leaves the pointer loaded and causes no write.
- R6: Each later byte received in full raises `regWrEn` for one clock. During that clock, `regAddr` is the pointer and `regWrData` is the byte, and each byte is acknowledged. A byte cut short by a start or stop condition causes no write.
- R7: The pointer increases by one after every write and wraps from all ones to zero.
- R8: In a read, the value on `regRdData` for the current pointer is sent MSB first: `sdaPullLow` is 1 exactly for the 0 bits. `sdaPullLow` changes only after a falling clock edge, or after a start or stop condition.
- R9: In a read, the slave releases the data line during the ninth clock and the pointer advances by one per byte sent. A master acknowledge (data low) starts the next byte at the new pointer. A master not-acknowledge stops transmission, with the data line released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| addrStrap | input | 1 | Static strap giving the lowest address bit |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls the data line low |
| regWrEn | output | 1 | One-cycle register write strobe |
| regAddr | output | PTR_W | Current register pointer, also the write address |
| regWrData | output | 8 | Byte to write |
| regRdData | input | 8 | Register-file contents at `regAddr`, used for reads |

## Verification
The bench uses the default parameters: the 011100 prefix, an eight-bit pointer and two synchronizer stages. The full-width pointer lets a write that starts at address 0xFF wrap to 0x00 within a two-byte transaction. Both strap values are driven at run time, so each of the two bus addresses is seen to be accepted and rejected. The synchronizer depth sets the delay that the master model's quarter-bit timing has to cover.

// File: rtl/twi_cmd_pkg.sv
package twi_cmd_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic shiftTx;
    logic loadTx;
    logic loadPtr;
    logic incPtr;
    logic wrStb;
    logic ackOn;
    logic ackOff;
    logic txOn;
    logic txOff;
  } dpCtl_t;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic bitLast;
    logic addrMatch;
    logic rwBit;
    logic sdaLvl;
  } dpStat_t;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_GOT, ST_ACK, ST_TX, ST_TXACK} state_t;
  typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_DATA} phase_t;
endpackage

// File: rtl/twi_cmd_dp.sv
module twi_cmd_dp
  import twi_cmd_pkg::*;
#(
  parameter logic [BYTE_W-3:0] ADDR_PREFIX = 6'b011100,
  parameter int PTR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             addrStrap,
  input  dpCtl_t           ctl,
  output dpStat_t          stat,
  input  logic [BYTE_W-1:0] rdData,
  output logic [PTR_W-1:0] ptrOut,
  output logic [BYTE_W-1:0] rxByte,
  output logic             pullLow
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev, sclSync, sdaSync;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic [CNT_W-1:0] bitCnt;
  logic [PTR_W-1:0] ptr;
  logic ackDrive, txMode;

  assign sclSync = sclPipe[SYNC_STAGES-1];
  assign sdaSync = sdaPipe[SYNC_STAGES-1];

  // Line synchronizers; idle bus level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= '0;
      bitCnt   <= '0;
      ptr      <= '0;
      ackDrive <= 1'b0;
      txMode   <= 1'b0;
    end else begin
      if (ctl.clrCnt) bitCnt <= '0;
      else if (ctl.shiftIn || ctl.shiftTx) bitCnt <= bitCnt + 1'b1;

      if (ctl.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaSync};

      if (ctl.loadTx) txShift <= rdData;
      else if (ctl.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};

      if (ctl.loadPtr) ptr <= rxShift[PTR_W-1:0];
      else if (ctl.incPtr) ptr <= ptr + 1'b1;

      if (ctl.ackOff) ackDrive <= 1'b0;
      else if (ctl.ackOn) ackDrive <= 1'b1;

      if (ctl.txOff) txMode <= 1'b0;
      else if (ctl.txOn) txMode <= 1'b1;
    end
  end

  assign stat.sclRise   = sclSync & ~sclPrev;
  assign stat.sclFall   = ~sclSync & sclPrev;
  assign stat.startDet  = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stat.stopDet   = sclSync & sclPrev & ~sdaPrev & sdaSync;
  assign stat.bitLast   = (bitCnt == CNT_W'(BYTE_W - 1));
  assign stat.addrMatch = (rxShift[BYTE_W-1:1] == {ADDR_PREFIX, addrStrap});
  assign stat.rwBit     = rxShift[0];
  assign stat.sdaLvl    = sdaSync;

  assign ptrOut  = ptr;
  assign rxByte  = rxShift;
  assign pullLow = ackDrive | (txMode & ~txShift[BYTE_W-1]);
endmodule

// File: rtl/twi_cmd_ctrl.sv
module twi_cmd_ctrl
  import twi_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  output dpCtl_t  ctl
);
  state_t st, stN;
  phase_t ph, phN;
  logic goTx, goTxN;
  logic mAck, mAckN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st   <= ST_IDLE;
      ph   <= PH_ADDR;
      goTx <= 1'b0;
      mAck <= 1'b0;
    end else begin
      st   <= stN;
      ph   <= phN;
      goTx <= goTxN;
      mAck <= mAckN;
    end
  end

  always_comb begin
    ctl   = '0;
    stN   = st;
    phN   = ph;
    goTxN = goTx;
    mAckN = mAck;
    if (stat.startDet) begin
      ctl.ackOff = 1'b1;
      ctl.txOff  = 1'b1;
      ctl.clrCnt = 1'b1;
      stN = ST_RX;
      phN = PH_ADDR;
    end else if (stat.stopDet) begin
      ctl.ackOff = 1'b1;
      ctl.txOff  = 1'b1;
      stN = ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_RX: if (stat.sclRise) begin
          ctl.shiftIn = 1'b1;
          if (stat.bitLast) stN = ST_GOT;
        end
        ST_GOT: if (stat.sclFall) begin
          unique case (ph)
            PH_ADDR: if (stat.addrMatch) begin
              ctl.ackOn  = 1'b1;
              ctl.clrCnt = 1'b1;
              goTxN = stat.rwBit;
              phN   = PH_CMD;
              stN   = ST_ACK;
            end else begin
              stN = ST_IDLE;
            end
            PH_CMD: begin
              ctl.loadPtr = 1'b1;
              ctl.ackOn   = 1'b1;
              ctl.clrCnt  = 1'b1;
              phN = PH_DATA;
              stN = ST_ACK;
            end
            default: begin
              ctl.wrStb  = 1'b1;
              ctl.incPtr = 1'b1;
              ctl.ackOn  = 1'b1;
              ctl.clrCnt = 1'b1;
              stN = ST_ACK;
            end
          endcase
        end
        ST_ACK: if (stat.sclFall) begin
          ctl.ackOff = 1'b1;
          if (goTx) begin
            ctl.loadTx = 1'b1;
            ctl.txOn   = 1'b1;
            stN = ST_TX;
          end else begin
            stN = ST_RX;
          end
        end
        ST_TX: if (stat.sclFall) begin
          if (stat.bitLast) begin
            ctl.txOff = 1'b1;
            stN = ST_TXACK;
          end else begin
            ctl.shiftTx = 1'b1;
          end
        end
        ST_TXACK: begin
          if (stat.sclRise) begin
            mAckN = ~stat.sdaLvl;
            ctl.incPtr = 1'b1;
          end
          if (stat.sclFall) begin
            if (mAck) begin
              ctl.loadTx = 1'b1;
              ctl.txOn   = 1'b1;
              ctl.clrCnt = 1'b1;
              stN = ST_TX;
            end else begin
              stN = ST_IDLE;
            end
          end
        end
        default: stN = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twi_cmd_slave.sv
module twi_cmd_slave
  import twi_cmd_pkg::*;
#(
  parameter logic [5:0] ADDR_PREFIX = 6'b011100,
  parameter int PTR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             addrStrap,
  output logic             sdaPullLow,
  output logic             regWrEn,
  output logic [PTR_W-1:0] regAddr,
  output logic [7:0]       regWrData,
  input  logic [7:0]       regRdData
);
  dpCtl_t  ctl;
  dpStat_t stat;

  twi_cmd_dp #(
    .ADDR_PREFIX(ADDR_PREFIX),
    .PTR_W(PTR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .addrStrap(addrStrap),
    .ctl(ctl),
    .stat(stat),
    .rdData(regRdData),
    .ptrOut(regAddr),
    .rxByte(regWrData),
    .pullLow(sdaPullLow)
  );

  twi_cmd_ctrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .stat(stat),
    .ctl(ctl)
  );

  assign regWrEn = ctl.wrStb;
endmodule

// File: rtl/twi_cmd_chk.sv
module twi_cmd_chk
  import twi_cmd_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sdaPullLow,
  input logic             regWrEn,
  input logic [PTR_W-1:0] regAddr,
  input dpStat_t          stat
);
  AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn); // R6

  AST_WR_ON_SCL_FALL: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> stat.sclFall); // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regAddr == PTR_W'($past(regAddr) + 1'b1))); // R7

  AST_SDA_CHANGE_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(stat.sclFall) && !$past(stat.startDet) && !$past(stat.stopDet))
      |-> $stable(sdaPullLow)); // R8

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    $past(stat.stopDet) |-> !sdaPullLow); // R2

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    $past(stat.startDet) |-> (!sdaPullLow && !regWrEn)); // R2
endmodule

bind twi_cmd_slave twi_cmd_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .sdaPullLow(sdaPullLow),
  .regWrEn(regWrEn),
  .regAddr(regAddr),
  .stat(stat)
);

// File: tb/twi_cmd_slave_bench.sv
module twi_cmd_slave_bench;
  localparam int T = 8;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] cmd;
    logic [7:0] d0;
    logic [7:0] d1;
    logic [1:0] n;
    logic       ack;
  } vec_t;

  // addr byte, command, data0, data1, data count, expected address ack
  localparam vec_t VECS [6] = '{
    '{8'h70, 8'h10, 8'hA5, 8'h3C, 2'd2, 1'b1},
    '{8'h72, 8'h44, 8'h12, 8'h00, 2'd1, 1'b0},
    '{8'h70, 8'h40, 8'h00, 8'h00, 2'd0, 1'b1},
    '{8'h70, 8'hFF, 8'h11, 8'h22, 2'd2, 1'b1},
    '{8'h50, 8'h07, 8'h99, 8'h00, 2'd1, 1'b0},
    '{8'h70, 8'h80, 8'h01, 8'h00, 2'd1, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic strap = 1'b0;
  logic sdaPullLow, regWrEn;
  logic [7:0] regAddr, regWrData, regRdData;
  logic sdaBus;

  logic [7:0] mem [256];
  logic [7:0] wrA [64];
  logic [7:0] wrD [64];
  int wrCnt = 0;
  int checks = 0;
  int fails = 0;
  logic [7:0] expPtr = 8'h00;

  always #10 clk = ~clk;

  assign sdaBus = mSda & ~sdaPullLow;
  assign regRdData = mem[regAddr];

  twi_cmd_slave u_twi_cmd_slave (
    .clk(clk),
    .rstN(rstN),
    .sclIn(mScl),
    .sdaIn(sdaBus),
    .addrStrap(strap),
    .sdaPullLow(sdaPullLow),
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData)
  );

  always @(negedge clk) begin
    if (rstN && regWrEn) begin
      mem[regAddr] = regWrData;
      if (wrCnt < 64) begin
        wrA[wrCnt] = regAddr;
        wrD[wrCnt] = regWrData;
      end
      wrCnt = wrCnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    mSda = 1'b1; busWait(T);
    mScl = 1'b1; busWait(T);
    mSda = 1'b0; busWait(T);
    mScl = 1'b0; busWait(T);
  endtask

  task automatic stopCond();
    mSda = 1'b0; busWait(T);
    mScl = 1'b1; busWait(T);
    mSda = 1'b1; busWait(T);
  endtask

  task automatic sendBit(input logic b);
    mSda = b; busWait(T);
    mScl = 1'b1; busWait(2 * T);
    mScl = 1'b0; busWait(T);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    mSda = 1'b1; busWait(T);
    mScl = 1'b1; busWait(T);
    acked = ~sdaBus;
    busWait(T);
    mScl = 1'b0; busWait(T);
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b, output logic slaveHeld);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      busWait(T);
      mScl = 1'b1; busWait(T);
      b[i] = sdaBus;
      busWait(T);
      mScl = 1'b0;
    end
    busWait(T);
    mSda = ~giveAck; busWait(T);
    mScl = 1'b1; busWait(T);
    slaveHeld = sdaPullLow;
    busWait(T);
    mScl = 1'b0; busWait(T);
    mSda = 1'b1;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic ack;
    logic held;
    logic [7:0] rb;
    int base;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

    busWait(5);
    // R1: reset state
    check("R1 pull", sdaPullLow, 0);
    check("R1 wren", regWrEn, 0);
    check("R1 addr", regAddr, 0);
    rstN = 1'b1;
    busWait(T);

    // Vector walk: R3 R4 R5 R6 R7
    foreach (VECS[v]) begin
      base = wrCnt;
      startCond();
      sendByte(VECS[v].addr, ack);
      check(VECS[v].ack ? "R3 addr ack" : "R4 addr noack", ack, VECS[v].ack);
      sendByte(VECS[v].cmd, ack);
      check(VECS[v].ack ? "R5 cmd ack" : "R4 cmd noack", ack, VECS[v].ack);
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        sendByte(i == 0 ? VECS[v].d0 : VECS[v].d1, ack);
        check(VECS[v].ack ? "R6 data ack" : "R4 data noack", ack, VECS[v].ack);
      end
      stopCond();
      busWait(T);
      if (VECS[v].ack) begin
        check("R6 write count", wrCnt - base, VECS[v].n);
        for (int i = 0; i < int'(VECS[v].n); i++) begin
          check("R7 write addr", wrA[base + i], 8'(VECS[v].cmd + 8'(i)));
          check("R6 write data", wrD[base + i], i == 0 ? VECS[v].d0 : VECS[v].d1);
        end
        expPtr = 8'(VECS[v].cmd + 8'(VECS[v].n));
        check("R5 pointer", regAddr, expPtr);
      end else begin
        check("R4 no writes", wrCnt - base, 0);
        check("R4 pointer kept", regAddr, expPtr);
      end
      check("R2 released after stop", sdaPullLow, 0);
    end

    // R3: strap selects the low address bit
    strap = 1'b1;
    busWait(T);
    base = wrCnt;
    startCond();
    sendByte(8'h72, ack);
    check("R3 strap1 match", ack, 1);
    sendByte(8'h05, ack);
    sendByte(8'h77, ack);
    stopCond();
    busWait(T);
    check("R3 strap1 write", wrCnt - base, 1);
    check("R3 strap1 data", wrD[base], 8'h77);
    check("R7 strap1 pointer", regAddr, 8'h06);
    startCond();
    sendByte(8'h70, ack);
    check("R3 strap1 rejects 0x38", ack, 0);
    stopCond();
    strap = 1'b0;
    busWait(T);

    // R8 R9: write pointer, repeated start, read two bytes
    base = wrCnt;
    startCond();
    sendByte(8'h70, ack);
    sendByte(8'h20, ack);
    sendByte(8'h55, ack);
    startCond();
    sendByte(8'h71, ack);
    check("R3 read addr ack", ack, 1);
    recvByte(1'b1, rb, held);
    check("R8 read byte0", rb, 8'h21 ^ 8'h5A);
    check("R9 released at master ack", held, 0);
    recvByte(1'b0, rb, held);
    check("R8 read byte1", rb, 8'h22 ^ 8'h5A);
    check("R9 released at master nack", held, 0);
    busWait(T);
    check("R9 idle after nack", sdaPullLow, 0);
    stopCond();
    busWait(T);
    check("R6 write before restart", wrCnt - base, 1);
    check("R9 pointer after read", regAddr, 8'h23);

    // R2: start in the middle of a command byte restarts address phase
    base = wrCnt;
    startCond();
    sendByte(8'h70, ack);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    startCond();
    sendByte(8'h70, ack);
    check("R2 restart addr ack", ack, 1);
    sendByte(8'h33, ack);
    stopCond();
    busWait(T);
    check("R2 restart pointer", regAddr, 8'h33);
    check("R2 restart no write", wrCnt - base, 0);

    // R6: stop in the middle of a data byte causes no write
    base = wrCnt;
    startCond();
    sendByte(8'h70, ack);
    sendByte(8'h60, ack);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    stopCond();
    busWait(T);
    check("R6 partial byte no write", wrCnt - base, 0);
    check("R5 pointer kept after partial", regAddr, 8'h60);
    check("R2 released", sdaPullLow, 0);

    finishRun();
  end
endmodule